// File: doc/BRIEF.md
# UART receive queue with trigger level and character timeout

This block holds received serial bytes for a host in a 16-entry first-in first-out queue. The deserializer ahead of it presents each finished byte with a one-cycle valid strobe. The host pops bytes with a read strobe. A byte control register, written through a write strobe, turns the queue on or off, flushes it, and selects how many stored bytes count as "enough". The block reports when that many bytes are stored, so an interrupt controller elsewhere can act.

A character timeout detector watches for bytes left sitting in the queue. It counts bit-period ticks, and its window is four character times at the current line settings. Each accepted byte restarts the window. A host read that leaves bytes behind also restarts it. If the window runs out while bytes are stored, a timeout-pending flag is raised. The transmit-queue flush bit of the control register is not acted on here. It is only passed out as a one-cycle pulse.

Outputs are combinational from state: read data, data-ready, fill count and the trigger indication. The overrun and transmit-flush pulses are registered. They appear in the cycle after the event that causes them.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: After reset the queue is empty and the stored control bits are 0. `fill_count`, `data_ready`, `at_trigger`, `timeout_pend`, `overrun`, `txq_flush` and `rd_data` are all 0.
- R2: While enabled, each `rx_valid` stores `rx_byte` at the clock edge, up to 16 bytes. `fill_count` gives the number stored and `data_ready` is high whenever it is non-zero. Reads with `rd_stb` return bytes in arrival order: `rd_data` shows the oldest byte during the strobe cycle, and that byte is removed at the edge.
- R3: A byte that arrives while 16 bytes are stored is discarded and the contents are unchanged. `overrun` is high for exactly the one cycle after that edge.
- R4: A read of an empty queue returns 0 and changes nothing.
- R5: Control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. While enabled, `at_trigger` is high when `fill_count` is at or above the selected level.
- R6: Control bit 0 enables the queue. While it is 0, received bytes are ignored and `fill_count` stays 0.
- R7: A control write keeps only bits 7, 6, 3 and 0 of the written value (mask 0xC9). The kept value is visible on `ctl_q` after the write edge.
- R8: Writing control bit 1 as 1 empties the receive queue and clears `timeout_pend`. It also stops the timeout counter. A byte or read in the same cycle is discarded.
- R9: Writing control bit 2 as 1 produces a one-cycle `txq_flush` pulse in the cycle after the write.
- R10: A control write whose bit 0 differs from the stored enable bit acts as if bits 1 and 2 were both set: the receive queue is emptied and `txq_flush` pulses.
- R11: One character lasts 1 start bit, plus (`line_ctl[1:0]` + 5) data bits, plus 1 parity bit when `line_ctl[3]` is 1, plus 2 stop bits when `line_ctl[2]` is 1 (1 stop bit otherwise). The timeout window is four characters long, counted in `bit_tick` pulses and started by each accepted byte. When the last tick of the window arrives and the queue is not empty, `timeout_pend` is set.
- R12: Any host read clears `timeout_pend`. A read that leaves bytes stored restarts the full timeout window. A read that empties the queue drops `data_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| line_ctl | input | 4 | Line settings: [1:0] data length code, [2] two stop bits, [3] parity present |
| bit_tick | input | 1 | One pulse per serial bit period |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| data_ready | output | 1 | At least one byte is stored |
| fill_count | output | 5 | Number of stored bytes |
| at_trigger | output | 1 | Fill count at or above the trigger level |
| timeout_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | One-cycle pulse: a byte was dropped because the queue was full |
| txq_flush | output | 1 | One-cycle pulse: transmit queue flush request |
| ctl_q | output | 8 | Retained control bits |

## Verification
The bench builds the block with its default parameters: a depth of 16 and a window of four characters. With these values, the full trigger table, overrun on the seventeenth byte and exact timeout edges can all be reached within a few hundred ticks. Two line settings are exercised: the shortest character (7 bits, window 28 ticks) and the longest (12 bits, window 48 ticks). For each, the bench checks that the pending flag is still clear one tick before the window ends and set on the final tick. It also checks that a read leaving a byte behind pushes the expiry a full window later.

// File: rtl/rxq_pkg.sv
// Package: shared constants for the receive queue.
// Assumes an 8-bit byte and the bit positions of the byte control register.
package rxq_pkg;
    localparam int BYTE_W    = 8;
    localparam int CB_ENABLE = 0;
    localparam int CB_RXRST  = 1;
    localparam int CB_TXRST  = 2;
    localparam logic [7:0] CTL_KEEP = 8'hC9;

    // Trigger level selected by control bits 7:6.
    function automatic int trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/rxq_ctrl.sv
// Control register decode.
// Keeps the sticky control bits and turns reset bits into one-cycle actions.
// A change of the enable bit forces both queue resets.
// Assumes at most one write per cycle.
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_q,
    output logic       flush_rx,
    output logic       txq_flush
);
    logic toggle;

    // Detect a change of the enable bit and derive the receive flush.
    always_comb begin
        toggle   = ctl_we && (ctl_wdata[CB_ENABLE] != ctl_q[CB_ENABLE]);
        flush_rx = toggle || (ctl_we && ctl_wdata[CB_RXRST]);
    end

    // Store the retained bits and register the transmit flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            txq_flush <= 1'b0;
        end else begin
            if (ctl_we) ctl_q <= ctl_wdata & CTL_KEEP;
            txq_flush <= toggle || (ctl_we && ctl_wdata[CB_TXRST]);
        end
    end
endmodule

// File: rtl/rxq_store.sv
// Circular byte store with fill count.
// The caller only asserts push when there is room and pop when the store is
// not empty. Flush has priority over push and pop. The drop input registers
// the overrun pulse.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    input  logic             flush,
    input  logic             drop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Present the oldest entry, or zero when empty.
    always_comb head = (count != '0) ? mem[rd_ptr] : '0;

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= din;
    end

    // Maintain the pointers, count and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= drop;
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_timer.sv
// Character timeout detector.
// Works out the character length from the line settings and counts
// TCHARS characters of bit ticks after each restart. When the window ends
// with data stored, it raises the pending flag. A read clears the flag, and
// clear also stops the counter.
module rxq_timer #(
    parameter int TCHARS = 4,
    localparam int MAXCH = 12,
    localparam int TMR_W = $clog2(TCHARS * MAXCH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] line_ctl,
    input  logic       tick,
    input  logic       restart,
    input  logic       rd,
    input  logic       clear,
    input  logic       nonempty,
    output logic       pend
);
    logic [3:0]       ch_bits;
    logic [TMR_W-1:0] last, cnt;
    logic             run, expire;

    // Character length (start, data, parity, stop) and the last window count.
    always_comb begin
        ch_bits = 4'd6 + {2'b00, line_ctl[1:0]} + {3'b000, line_ctl[3]}
                + (line_ctl[2] ? 4'd2 : 4'd1);
        last    = TMR_W'(TCHARS * int'(ch_bits) - 1);
        expire  = run && tick && !restart && (cnt == last);
    end

    // Run the window counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (restart) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (expire) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + TMR_W'(1);
        end
    end

    // Hold the pending flag; a read wins over expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)          pend <= 1'b0;
        else if (rd)                  pend <= 1'b0;
        else if (expire && nonempty)  pend <= 1'b1;
    end
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
// Receive queue top.
// Ties together the control decode, the byte store and the timeout detector.
// Accepts a byte only while enabled, not full and not flushing. Pops only
// when the queue is not empty. Assumes single-cycle strobes from the
// deserializer and the host.
module uart_rx_fifo_ctl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TCHARS = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic [3:0]        line_ctl,
    input  logic              bit_tick,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              data_ready,
    output logic [CNT_W-1:0]  fill_count,
    output logic              at_trigger,
    output logic              timeout_pend,
    output logic              overrun,
    output logic              txq_flush,
    output logic [7:0]        ctl_q
);
    logic flush_rx, en, full, push_ok, pop_ok, drop, restart;

    rxq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_q     (ctl_q),
        .flush_rx  (flush_rx),
        .txq_flush (txq_flush)
    );

    // Qualify the byte and read strobes and decide on a timeout restart.
    always_comb begin
        en      = ctl_q[CB_ENABLE];
        full    = (fill_count == CNT_W'(DEPTH));
        push_ok = rx_valid && en && !full && !flush_rx;
        drop    = rx_valid && en && full && !flush_rx;
        pop_ok  = rd_stb && (fill_count != '0) && !flush_rx;
        restart = push_ok || (pop_ok && (fill_count > CNT_W'(1)));
    end

    rxq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_ok),
        .din     (rx_byte),
        .pop     (pop_ok),
        .flush   (flush_rx),
        .drop    (drop),
        .head    (rd_data),
        .count   (fill_count),
        .overrun (overrun)
    );

    rxq_timer #(.TCHARS(TCHARS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_ctl (line_ctl),
        .tick     (bit_tick),
        .restart  (restart),
        .rd       (rd_stb),
        .clear    (flush_rx),
        .nonempty (fill_count != '0),
        .pend     (timeout_pend)
    );

    // Status outputs derived from the count and the selected level.
    always_comb begin
        data_ready = (fill_count != '0);
        at_trigger = en && (int'(fill_count) >= trig_level(ctl_q[7:6]));
    end
endmodule

// File: rtl/rxq_chk.sv
// Checker for the receive queue: temporal properties on the top-level ports.
module rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             ctl_we,
    input logic [7:0]       ctl_wdata,
    input logic             rd_stb,
    input logic [CNT_W-1:0] fill_count,
    input logic             timeout_pend,
    input logic             overrun,
    input logic             txq_flush,
    input logic [7:0]       ctl_q
);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    p_ovr_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(rx_valid) && $past(fill_count) == CNT_W'(DEPTH)));

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && fill_count == '0 && !rx_valid && !ctl_we) |=> fill_count == '0);

    p_off_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[0] |-> fill_count == '0);

    p_ctl_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_q == ($past(ctl_wdata) & 8'hC9));

    p_rx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[1]) |=> (fill_count == '0 && !timeout_pend));

    p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        txq_flush |-> ($past(ctl_we) &&
                       ($past(ctl_wdata[2]) || ($past(ctl_wdata[0]) != $past(ctl_q[0])))));

    p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[0] != ctl_q[0]) |=> fill_count == '0);

    p_pend_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> fill_count != '0);

    p_read_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ctl_we) |=> !timeout_pend);
endmodule

bind uart_rx_fifo_ctl rxq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_rx_fifo_ctl_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [3:0] line_ctl = '0;
    logic       bit_tick = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, at_trigger, timeout_pend, overrun, txq_flush;
    logic [4:0] fill_count;
    logic [7:0] ctl_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic ov_seen, tx_seen;
    logic [7:0] got;

    always #4 clk = ~clk;   // 125 MHz

    uart_rx_fifo_ctl u_dut (.*);

    // Vector: {trigger code[1:0], bytes to push[5:0], expected count[4:0], expected trigger}
    localparam logic [13:0] VEC [0:8] = '{
        {2'b00, 6'd1,  5'd1,  1'b1},
        {2'b00, 6'd0,  5'd0,  1'b0},
        {2'b01, 6'd3,  5'd3,  1'b0},
        {2'b01, 6'd4,  5'd4,  1'b1},
        {2'b10, 6'd7,  5'd7,  1'b0},
        {2'b10, 6'd8,  5'd8,  1'b1},
        {2'b11, 6'd13, 5'd13, 1'b0},
        {2'b11, 6'd14, 5'd14, 1'b1},
        {2'b11, 6'd18, 5'd16, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0; ov_seen = overrun;
    endtask

    task automatic ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0; tx_seen = txq_flush;
    endtask

    task automatic rd();
        @(negedge clk); rd_stb = 1'b1; #1 got = rd_data;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog expired actual=0 expected=1");
        n_chk++; n_bad++;
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fill_count == 0 && !data_ready && !at_trigger && !timeout_pend,
              "R1 flags", {fill_count, data_ready, at_trigger, timeout_pend}, 0);
        check(!overrun && !txq_flush && ctl_q == 0 && rd_data == 0,
              "R1 outputs", {overrun, txq_flush, ctl_q, rd_data}, 0);

        // R6 disabled: bytes ignored
        push(8'h5A);
        check(fill_count == 0, "R6 ignored while disabled", fill_count, 0);

        // R5 trigger table walk
        foreach (VEC[k]) begin
            ctl({VEC[k][13:12], 6'b000011});
            for (int i = 0; i < int'(VEC[k][11:6]); i++) push(8'(i));
            check(fill_count == VEC[k][5:1], $sformatf("R5 count vec%0d", k),
                  fill_count, VEC[k][5:1]);
            check(at_trigger == VEC[k][0], $sformatf("R5 trigger vec%0d", k),
                  at_trigger, VEC[k][0]);
        end
        // R3 last vector: 18 pushes into 16 entries; last push overran
        check(ov_seen == 1'b1, "R3 overrun pulse", ov_seen, 1);
        @(negedge clk);
        check(overrun == 1'b0, "R3 overrun one cycle", overrun, 0);
        // R2 order survives overrun: head is byte 0
        rd();
        check(got == 8'h00, "R2 first out", got, 0);

        // R8 rx reset empties
        ctl(8'h03);
        check(fill_count == 0 && !data_ready, "R8 flush", fill_count, 0);

        // R2 ordering
        push(8'hA1); push(8'hB2); push(8'hC3);
        check(data_ready == 1'b1, "R2 data ready", data_ready, 1);
        rd(); check(got == 8'hA1, "R2 order 1", got, 8'hA1);
        rd(); check(got == 8'hB2, "R2 order 2", got, 8'hB2);
        rd(); check(got == 8'hC3, "R2 order 3", got, 8'hC3);
        check(!data_ready, "R12 empty drops ready", data_ready, 0);

        // R4 empty read
        rd();
        check(got == 8'h00 && fill_count == 0, "R4 empty read", got, 0);

        // R7 retained mask (enable stays 1)
        ctl(8'hF1);
        check(ctl_q == 8'hC1, "R7 mask", ctl_q, 8'hC1);
        check(tx_seen == 1'b0, "R9 no pulse without bit2", tx_seen, 0);

        // R9 transmit reset pulse
        ctl(8'h05);
        check(tx_seen == 1'b1, "R9 tx pulse", tx_seen, 1);
        @(negedge clk);
        check(txq_flush == 1'b0, "R9 pulse one cycle", txq_flush, 0);

        // R10 enable toggle flushes and pulses tx
        push(8'h11); push(8'h22);
        ctl(8'h00);
        check(fill_count == 0 && tx_seen, "R10 toggle off", {fill_count, tx_seen}, 1);
        check(ctl_q == 8'h00, "R10 ctl off", ctl_q, 0);
        ctl(8'h01);
        check(tx_seen == 1'b1, "R10 toggle on pulse", tx_seen, 1);

        // R11 shortest character: 7 bits, window 28 ticks
        line_ctl = 4'b0000;
        push(8'h33);
        ticks(27);
        check(!timeout_pend, "R11 not before 28", timeout_pend, 0);
        ticks(1);
        check(timeout_pend, "R11 at 28", timeout_pend, 1);

        // R12 read clears pend, empties
        rd();
        check(!timeout_pend && !data_ready, "R12 read clears", {timeout_pend, data_ready}, 0);

        // R11 longest character: 12 bits, window 48 ticks
        line_ctl = 4'b1111;
        push(8'h44);
        ticks(47);
        check(!timeout_pend, "R11 not before 48", timeout_pend, 0);
        ticks(1);
        check(timeout_pend, "R11 at 48", timeout_pend, 1);

        // R8 rx reset clears pend
        ctl(8'h03);
        check(!timeout_pend && fill_count == 0, "R8 clears pend", timeout_pend, 0);

        // R12 read leaving data restarts window
        line_ctl = 4'b0000;
        push(8'h55); push(8'h66);
        ticks(20);
        rd();
        check(got == 8'h55, "R12 read value", got, 8'h55);
        ticks(27);
        check(!timeout_pend, "R12 restarted window", timeout_pend, 0);
        ticks(1);
        check(timeout_pend, "R12 expiry after restart", timeout_pend, 1);

        summary();
    end
endmodule